// File: doc/BRIEF.md
# Shared-Term Programmable Logic Array

A purely combinational logic array whose two planes are both set by configuration. The AND-plane builds a fixed number of product terms. Each term may take the true or the complemented form of every input. The OR-plane then gives each output the OR of any chosen subset of those terms. Because the term-to-output links are configurable, a term needed by several functions is built once and fanned out to each output that uses it.

The array is loaded through two parallel configuration vectors, one for each plane, and held static while the data input changes. Typical use is a small block of glue logic whose equations are written as sums of products. Examples are a 4-bit prime detector beside a second set detector that shares one term with it, or a half adder.

Top module: `pla_shared_array`

## Requirements
- R1: Product term t is the AND of the input literals enabled for it. Bit t*2*N_IN+2*i of `and_cfg_i` enables input i in true form, and bit t*2*N_IN+2*i+1 enables its complement.
- R2: A product term with no literal enabled evaluates to 1.
- R3: A product term that enables both polarities of the same input evaluates to 0 for every input value.
- R4: Output o is the OR of every term t whose link bit t*N_OUT+o in `or_cfg_i` is set, and is 1 only when such a linked term is active.
- R5: One term linked to several outputs drives each of them.
- R6: An output with no term linked drives 0, and so does every output when both configuration vectors are all zero.
- R7: With five terms, the array gives out[0] = 1 exactly for inputs 2, 3, 5, 7, 11 and 13 and out[1] = 1 exactly for inputs 3, 11, 14 and 15. The term covering 3 and 11 is linked to both outputs.
- R8: With three terms on in[0] and in[1], out[0] gives their sum (XOR) and out[1] gives their carry (AND). in[3:2] then has no effect.
- R9: Outputs follow a change on `in_i` in the same time step, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | N_IN | Data inputs to the AND-plane |
| and_cfg_i | input | N_TERM*2*N_IN | AND-plane literal enables, one true/complement pair per input per term |
| or_cfg_i | input | N_TERM*N_OUT | OR-plane links, term-major, one bit per output |
| out_o | output | N_OUT | Sum-of-products outputs |

## Verification
The assertions are immediate and combinational. They assume only that the configuration vectors and inputs are known values, with no X or Z, at the time they are evaluated. The stimulus always loads a full configuration before it drives data, and it changes inputs on the falling clock edge. As a result, every checked value comes from fully defined inputs. Each configuration is swept over all sixteen input values.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // bit index of a literal enable in the AND-plane vector
  function automatic int and_idx(int n_in, int term, int inp, bit comp);
    return term * 2 * n_in + 2 * inp + int'(comp);
  endfunction

  // bit index of a term-to-output link in the OR-plane vector
  function automatic int or_idx(int n_out, int term, int outp);
    return term * n_out + outp;
  endfunction
endpackage

// File: rtl/pla_lit_gen.sv
module pla_lit_gen #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0]   in_i,
  output logic [2*N_IN-1:0] lit_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_o[2*i]   = in_i[i];
    assign lit_o[2*i+1] = ~in_i[i];
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8
) (
  input  logic [2*N_IN-1:0]        lit_i,
  input  logic [N_TERM*2*N_IN-1:0] cfg_i,
  output logic [N_TERM-1:0]        term_o
);
  localparam int LW = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LW-1:0] mask;
    assign mask      = cfg_i[t*LW +: LW];
    // unselected literals read as 1
    assign term_o[t] = &(~mask | lit_i);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]       term_i,
  input  logic [N_TERM*N_OUT-1:0] cfg_i,
  output logic [N_OUT-1:0]        out_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign col[t] = cfg_i[t*N_OUT+o];
    end
    assign out_o[o] = |(col & term_i);
  end
endmodule

// File: rtl/pla_shared_array.sv
module pla_shared_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic [N_IN-1:0]          in_i,
  input  logic [N_TERM*2*N_IN-1:0] and_cfg_i,
  input  logic [N_TERM*N_OUT-1:0]  or_cfg_i,
  output logic [N_OUT-1:0]         out_o
);
  import pla_pkg::*;

  localparam int LW = 2 * N_IN;

  logic [LW-1:0]     lit;
  logic [N_TERM-1:0] term;

  pla_lit_gen #(.N_IN(N_IN)) u_lit (
    .in_i (in_i),
    .lit_o(lit)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .lit_i (lit),
    .cfg_i (and_cfg_i),
    .term_o(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i(term),
    .cfg_i (or_cfg_i),
    .out_o (out_o)
  );

  // checks across plane boundaries
  always_comb begin
    logic hit;
    logic any_link;
    for (int t = 0; t < N_TERM; t++) begin
      if (and_cfg_i[t*LW +: LW] == '0)
        p_empty_term_one_r2: assert (term[t] == 1'b1);
      for (int i = 0; i < N_IN; i++) begin
        if (and_cfg_i[and_idx(N_IN, t, i, 1'b0)] && and_cfg_i[and_idx(N_IN, t, i, 1'b1)])
          p_contra_term_zero_r3: assert (term[t] == 1'b0);
      end
    end
    for (int o = 0; o < N_OUT; o++) begin
      hit      = 1'b0;
      any_link = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        if (or_cfg_i[or_idx(N_OUT, t, o)]) begin
          any_link = 1'b1;
          if (term[t]) begin
            hit = 1'b1;
            p_shared_term_drives_r5: assert (out_o[o] == 1'b1);
          end
        end
      end
      if (!any_link)
        p_unlinked_out_zero_r6: assert (out_o[o] == 1'b0);
      if (out_o[o])
        p_out_has_source_r4: assert (hit);
    end
  end
endmodule

// File: tb/pla_shared_array_test.sv
module pla_shared_array_test;
  localparam int N_IN   = 4;
  localparam int N_TERM = 8;
  localparam int N_OUT  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_IN-1:0]          in_i = '0;
  logic [N_TERM*2*N_IN-1:0] and_cfg = '0;
  logic [N_TERM*N_OUT-1:0]  or_cfg = '0;
  logic [N_OUT-1:0]         out_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk; // 125 MHz

  pla_shared_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) uut (
    .in_i     (in_i),
    .and_cfg_i(and_cfg),
    .or_cfg_i (or_cfg),
    .out_o    (out_o)
  );

  task automatic clear_cfg();
    and_cfg = '0;
    or_cfg  = '0;
  endtask

  // comp=0 true literal, comp=1 complement
  task automatic lit(int t, int i, bit comp);
    and_cfg[t*2*N_IN + 2*i + int'(comp)] = 1'b1;
  endtask

  task automatic link(int t, int o);
    or_cfg[t*N_OUT + o] = 1'b1;
  endtask

  function automatic bit in_set(int v, int a, int b, int c, int d, int e, int f);
    return v == a || v == b || v == c || v == d || v == e || v == f;
  endfunction

  // expected outputs from the requirement text, per mode
  function automatic logic [1:0] expect_fn(int mode, int v);
    logic [1:0] r;
    logic a, b;
    a = v[0];
    b = v[1];
    case (mode)
      1: begin
        r[0] = in_set(v, 2, 3, 5, 7, 11, 13);
        r[1] = in_set(v, 3, 11, 14, 15, 15, 15);
      end
      2: r = {a & b, a ^ b};
      3: r = 2'b01;
      4: r = 2'b00;
      5: r = {1'b0, in_set(v, 2, 3, 5, 7, 11, 13)};
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  task automatic check(string req, int mode, int v);
    logic [1:0] exp;
    exp = expect_fn(mode, v);
    n_checks++;
    if (out_o !== exp) begin
      n_fail++;
      $display("FAIL %s in=%0d actual=%b expected=%b", req, v, out_o, exp);
    end
  endtask

  task automatic sweep(string req, int mode);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      in_i = v[N_IN-1:0];
      @(posedge clk);
      #1;
      check(req, mode, v);
    end
  endtask

  task automatic load_prime();
    clear_cfg();
    lit(0, 3, 1); lit(0, 2, 1); lit(0, 1, 0);
    lit(1, 3, 1); lit(1, 1, 0); lit(1, 0, 0);
    lit(2, 2, 1); lit(2, 1, 0); lit(2, 0, 0);
    lit(3, 2, 0); lit(3, 1, 1); lit(3, 0, 0);
    lit(4, 3, 0); lit(4, 2, 0); lit(4, 1, 0);
    link(0, 0); link(1, 0); link(2, 0); link(3, 0);
    link(2, 1); link(4, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R6: all-zero configuration drives zero everywhere
    sweep("R6_blank", 0);

    // R7 R5 R1 R4: prime detector plus shared-term detector
    load_prime();
    sweep("R7_prime_shared", 1);

    // R9: output follows input with no clock edge
    @(negedge clk);
    in_i = 4'd13;
    #1;
    check("R9_comb", 1, 13);
    in_i = 4'd14;
    #1;
    check("R9_comb", 1, 14);

    // R6: drop out[1] links, out[0] unchanged
    or_cfg[2*N_OUT + 1] = 1'b0;
    or_cfg[4*N_OUT + 1] = 1'b0;
    sweep("R6_unlinked", 5);

    // R8: half adder on in[1:0], in[3:2] ignored
    clear_cfg();
    lit(0, 0, 0); lit(0, 1, 1);
    lit(1, 0, 1); lit(1, 1, 0);
    lit(2, 0, 0); lit(2, 1, 0);
    link(0, 0); link(1, 0); link(2, 1);
    sweep("R8_half_adder", 2);

    // R2: empty term on out[0] is constant 1
    clear_cfg();
    link(5, 0);
    sweep("R2_empty_term", 3);

    // R3: contradictory term linked to both outputs is constant 0
    clear_cfg();
    lit(6, 0, 0); lit(6, 0, 1); lit(6, 2, 0);
    link(6, 0); link(6, 1);
    sweep("R3_contra", 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule